// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller

This block collects up to a parameterised number of interrupt lines for a small processor core and turns them into one request signal. Each line is brought into the clock domain through a synchronizer chain. A transition from low to high is remembered as a pending bit in a status register. A line that simply stays high is not reported a second time. A mask register selects which lines may raise the request. The lowest lines are fixed as non-maskable; by default these are lines 0 and 1. The request is further gated by the core's global interrupt-enable input.

Every new edge also produces a one-cycle wake pulse. The core uses this pulse to clear its doze-enable and sleep-enable bits. Software reaches the status, mask and control registers through a simple single-cycle write port with a combinational read. It clears pending bits by writing ones to them. When the control enable bit is cleared, the controller works in bypass mode. In this mode, each new edge produces a one-cycle request pulse, gated only by the global enable, and the status register is not touched.

Top module: `edge_irq_ctrl`

## Requirements
- R1: In enabled mode, a line that goes from low to high sets status bit i (bit position i belongs to line i). The bit is set on the (SYNC_STAGES+1)-th rising clock edge after the line is first sampled high.
- R2: A line that is held high produces no further status set and no wake pulse. This includes the time after its status bit has been cleared by software.
- R3: Lines below N_FIXED (lines 0 and 1 by default) raise the request whatever their mask bit is. Any other line raises it only while its mask bit is 1.
- R4: irq_o is 0 whenever gie_i is 0. When gie_i rises while an unmasked status bit is pending, irq_o is 1 in that same cycle.
- R5: wake_o is a one-cycle pulse that follows every new edge on any line. This holds in either mode, whatever the mask is, and whatever gie_i is.
- R6: The register map has three addresses. Address 0 is status: reading returns the pending bits, and a write is write-one-to-clear. Address 1 is mask, which can be read and written. Address 2 is control: bit 0 is the controller enable and all other bits read 0. Read data follows reg_addr_i combinationally.
- R7: Writing 1 to a status bit clears it, and irq_o drops once no unmasked pending bit remains. If a clear and a new edge hit the same bit in the same cycle, the bit ends up set.
- R8: After reset, status is 0, mask is 0, enable is 1, and irq_o and wake_o are 0.
- R9: With enable at 0, each new edge drives irq_o high for exactly the one cycle of its wake pulse, provided gie_i is 1. Status is not changed by edges in this mode.
- R10: In enabled mode, irq_o is a level. It stays high for as long as an unmasked pending bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | N_LINES | Asynchronous interrupt lines, active high |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address (0 status, 1 mask, 2 control) |
| reg_wdata_i | input | N_LINES | Register write data |
| reg_rdata_o | output | N_LINES | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle pulse clearing the core's doze and sleep enables |

## Verification
The bench builds the block with N_LINES = 8, N_FIXED = 2 and SYNC_STAGES = 2. With eight lines, the highest line (7) can be exercised together with the non-maskable pair and a mask pattern that covers every bit. The two-stage synchronizer gives a three-edge latency, which the bench counts exactly. This makes it possible to line up a clear write with a new edge in the same cycle and to sample the single-cycle wake and bypass pulses.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_MASK   = 2'd1,
        ADDR_CTRL   = 2'd2
    } reg_addr_e;

    // Reset value of the controller enable bit
    localparam logic EN_RESET = 1'b1;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < STAGES; k++) begin
                chain_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                chain_q[k] <= chain_d[k];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eic_edge.sv
module eic_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] level_d;
    logic [WIDTH-1:0] level_q;

    always_comb begin
        level_d = lvl_i;
        rise_o  = lvl_i & ~level_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_FIXED = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] rise_i,
    input  logic               gie_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [N_LINES-1:0] wdata_i,
    output logic [N_LINES-1:0] rdata_o,
    output logic               irq_o,
    output logic               wake_o
);

    typedef struct packed {
        logic [N_LINES-1:0] status;
        logic [N_LINES-1:0] mask;
        logic               en;
        logic               wake;
        logic               byp;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic               wr_status;
    logic               wr_mask;
    logic               wr_ctrl;
    logic [N_LINES-1:0] eff_mask;
    logic               pending;

    // Lines below N_FIXED are never gated by the mask
    for (genvar g = 0; g < N_LINES; g++) begin : g_mask
        if (g < N_FIXED) begin : g_fixed
            assign eff_mask[g] = 1'b1;
        end else begin : g_gated
            assign eff_mask[g] = st_q.mask[g];
        end
    end

    always_comb begin
        wr_status = wr_i && (addr_i == ADDR_STATUS);
        wr_mask   = wr_i && (addr_i == ADDR_MASK);
        wr_ctrl   = wr_i && (addr_i == ADDR_CTRL);

        st_d = st_q;
        if (wr_mask) st_d.mask = wdata_i;
        if (wr_ctrl) st_d.en   = wdata_i[0];

        // Clear first, then set, so a same-cycle edge wins
        st_d.status = st_q.status & ~(wr_status ? wdata_i : '0);
        if (st_q.en) st_d.status = st_d.status | rise_i;

        st_d.wake = |rise_i;
        st_d.byp  = !st_q.en && (|rise_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.status <= '0;
            st_q.mask   <= '0;
            st_q.en     <= EN_RESET;
            st_q.wake   <= 1'b0;
            st_q.byp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pending = |(st_q.status & eff_mask);
        irq_o   = gie_i && (st_q.en ? pending : st_q.byp);
        wake_o  = st_q.wake;
        case (addr_i)
            ADDR_STATUS: rdata_o = st_q.status;
            ADDR_MASK:   rdata_o = st_q.mask;
            ADDR_CTRL:   rdata_o = {{(N_LINES-1){1'b0}}, st_q.en};
            default:     rdata_o = '0;
        endcase
    end

    // A status bit appears only from an edge seen while enabled
    assert_status_needs_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(st_q.status & ~$past(st_q.status))) |-> ($past(st_q.en) && (|$past(rise_i))));

    // Every newly set status bit comes with a wake pulse
    assert_wake_on_new_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(st_q.status & ~$past(st_q.status))) |-> wake_o);

    // Non-maskable pending bits always request when allowed
    assert_fixed_lines_request_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gie_i && st_q.en && (|st_q.status[N_FIXED-1:0])) |-> irq_o);

    // Global enable gates the request
    assert_request_needs_gie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_i |-> !irq_o);

    // Full clear without a new edge leaves nothing pending
    assert_full_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_status && (&wdata_i) && (rise_i == '0)) |=> (st_q.status == '0));

    // Bypass mode leaves status alone apart from software clears
    assert_bypass_keeps_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.en && !wr_status) |=> $stable(st_q.status));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int N_LINES     = 32,
    parameter int N_FIXED     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [N_LINES-1:0]         line_i,
    input  logic                       gie_i,
    input  logic                       reg_wr_i,
    input  logic [eic_pkg::ADDR_W-1:0] reg_addr_i,
    input  logic [N_LINES-1:0]         reg_wdata_i,
    output logic [N_LINES-1:0]         reg_rdata_o,
    output logic                       irq_o,
    output logic                       wake_o
);

    logic [N_LINES-1:0] sync_lvl;
    logic [N_LINES-1:0] rise;

    eic_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (line_i),
        .q_o    (sync_lvl)
    );

    eic_edge #(
        .WIDTH (N_LINES)
    ) i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (sync_lvl),
        .rise_o (rise)
    );

    eic_regs #(
        .N_LINES (N_LINES),
        .N_FIXED (N_FIXED)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise),
        .gie_i   (gie_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .irq_o   (irq_o),
        .wake_o  (wake_o)
    );

    // A line that stayed high through the last cycle never counts as an edge
    assert_held_line_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise & $past(sync_lvl)) == '0));

endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;

    localparam int N    = 8;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] lines;
    logic         gie;
    logic         wr;
    logic [1:0]   addr;
    logic [N-1:0] wdata;
    logic [N-1:0] rdata;
    logic         irq;
    logic         wake;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_irq_ctrl #(
        .N_LINES     (N),
        .N_FIXED     (2),
        .SYNC_STAGES (SYNC)
    ) i_edge_irq_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .line_i      (lines),
        .gie_i       (gie),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Raise one line and stop in the window after the latching edge
    task automatic raise(input int ln);
        @(negedge clk);
        lines[ln] = 1'b1;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lower_all();
        @(negedge clk);
        lines = '0;
        repeat (LAT + 1) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        @(negedge clk);
        chk("R8", "irq after reset", irq, 0);
        chk("R8", "wake after reset", wake, 0);
        reg_read(2'd0, d); chk("R8", "status after reset", d, 0);
        reg_read(2'd1, d); chk("R8", "mask after reset", d, 0);
        reg_read(2'd2, d); chk("R8", "enable after reset", d, 1);
    endtask

    task automatic t_masked_level();
        logic [N-1:0] d;
        raise(5);
        chk("R5", "wake pulse on masked edge", wake, 1);
        chk("R3", "masked line 5 gives no irq", irq, 0);
        reg_read(2'd0, d);
        chk("R1", "status bit 5 set", d, 8'h20);
        chk("R5", "wake lasts one cycle", wake, 0);
        reg_write(2'd1, 8'h20);
        @(negedge clk);
        chk("R3", "unmasked line 5 requests", irq, 1);
        gie = 1'b0; #1;
        chk("R4", "gie low blocks irq", irq, 0);
        @(negedge clk);
        gie = 1'b1; #1;
        chk("R4", "gie rise requests at once", irq, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R10", "request stays as a level", irq, 1);
    endtask

    task automatic t_clear_held();
        logic [N-1:0] d;
        bit saw_wake = 1'b0;
        reg_write(2'd0, 8'h20);
        @(negedge clk);
        chk("R7", "irq drops after clear", irq, 0);
        reg_read(2'd0, d);
        chk("R7", "status cleared by write-one", d, 0);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (wake) saw_wake = 1'b1;
        end
        reg_read(2'd0, d);
        chk("R2", "held line does not set again", d, 0);
        chk("R2", "held line gives no wake", saw_wake, 0);
        lower_all();
    endtask

    task automatic t_fixed_lines();
        logic [N-1:0] d;
        reg_write(2'd1, 8'h00);
        raise(0);
        chk("R3", "line 0 ignores mask", irq, 1);
        reg_write(2'd0, 8'h01);
        lower_all();
        raise(1);
        chk("R3", "line 1 ignores mask", irq, 1);
        reg_write(2'd0, 8'h02);
        lower_all();
        raise(2);
        chk("R3", "line 2 needs mask", irq, 0);
        reg_read(2'd0, d);
        chk("R1", "line 2 still latched", d, 8'h04);
        reg_write(2'd0, 8'hFF);
        lower_all();
    endtask

    task automatic t_collision();
        logic [N-1:0] d;
        reg_write(2'd1, 8'h80);
        @(negedge clk);
        lines[7] = 1'b1;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = 2'd0; wdata = 8'h80;
        @(posedge clk);
        #1 wr = 1'b0; wdata = '0;
        chk("R5", "wake on top line edge", wake, 1);
        reg_read(2'd0, d);
        chk("R7", "edge wins over same-cycle clear", d, 8'h80);
        chk("R7", "top line requests", irq, 1);
        reg_write(2'd0, 8'h80);
        lower_all();
    endtask

    task automatic t_regmap();
        logic [N-1:0] d;
        reg_write(2'd1, 8'hA5);
        reg_read(2'd1, d);
        chk("R6", "mask readback", d, 8'hA5);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, d);
        chk("R6", "control upper bits read 0", d, 8'h01);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, d);
        chk("R6", "write-one on empty status", d, 0);
        reg_write(2'd1, 8'h00);
    endtask

    task automatic t_bypass();
        logic [N-1:0] d;
        reg_write(2'd1, 8'hFF);
        reg_write(2'd2, 8'h00);
        raise(3);
        chk("R9", "bypass pulse on edge", irq, 1);
        chk("R5", "wake in bypass", wake, 1);
        @(negedge clk);
        chk("R9", "bypass pulse is one cycle", irq, 0);
        reg_read(2'd0, d);
        chk("R9", "bypass leaves status", d, 0);
        gie = 1'b0;
        raise(4);
        chk("R9", "bypass pulse gated by gie", irq, 0);
        chk("R5", "wake without gie", wake, 1);
        gie = 1'b1;
        reg_write(2'd2, 8'h01);
        reg_read(2'd0, d);
        chk("R9", "status empty after bypass", d, 0);
        chk("R9", "no request after re-enable", irq, 0);
        lower_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lines = '0; gie = 1'b1;
        wr = 1'b0; addr = '0; wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_level();
        t_clear_held();
        t_fixed_lines();
        t_collision();
        t_regmap();
        t_bypass();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule